// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This controller runs in the scan-clock domain and drives the dynamic phase-adjust port of a PLL. A single start request carries a direction bit, a 4-bit counter-select code and a step count. The controller checks the select code first. It then performs the requested number of single phase shifts one after another. For each shift it presents the direction and select outputs, raises the step strobe for a fixed number of cycles, drops it, and waits for the PLL's done flag to rise.

The done flag is taken as asynchronous. It passes through a two-flop synchroniser followed by an edge detector, and only a low-to-high transition completes a step. A timeout guards every wait. The controller reports three things: a busy level, a one-cycle completion pulse, and two sticky error flags, one for a rejected select code and one for a missing acknowledge.

States: `ST_IDLE` (waiting for a start request), `ST_SETUP` (outputs settle, strobe low), `ST_STROBE` (strobe high), `ST_WAIT` (strobe low, waiting for the done edge), `ST_FINISH` (completion pulse). Transitions:
- IDLE→IDLE when the select code is rejected.
- IDLE→FINISH when the step count is zero.
- IDLE→SETUP for any other accepted start.
- SETUP→STROBE after one cycle.
- STROBE→WAIT after `HOLD_CYC` cycles.
- WAIT→SETUP on a done edge while steps remain.
- WAIT→FINISH on the done edge of the last step.
- WAIT→IDLE on timeout.
- FINISH→IDLE after one cycle.

Top module: `phase_step_seq`

## Requirements
- R1: `ps_dir_o` and `ps_sel_o` take the requested values at least one cycle before the strobe rises. They hold those values while `busy_o` is high.
- R2: On every step `ps_step_o` is high for exactly `HOLD_CYC` consecutive cycles, and `HOLD_CYC` is at least 2.
- R3: A request for N steps produces exactly N strobe pulses. A new pulse starts only after the done edge of the previous one has been seen.
- R4: A step completes only on a low-to-high transition of `pll_done_i` seen through the two-flop synchroniser. A level that stays high does not complete the step.
- R5: The select codes are:
  - 0: all output counters
  - 1 to 10: counters C0 to C9
  - 11: the feedback counter
  - 12 to 15: invalid

  Codes 8 to 10 (C7 to C9) are also rejected when `WIDE_SEL`=0. A rejected request sets `err_sel_o`, produces no strobe and leaves `busy_o` low.
- R6: If no done edge arrives within `TIMEOUT_CYC` cycles of waiting, the sequence aborts to idle. This sets `err_timeout_o` and issues no completion pulse.
- R7: `busy_o` is high from the cycle after an accepted start until the completion pulse ends. A start request while busy is ignored.
- R8: `done_o` pulses for one cycle after the last step's done edge. A step count of zero gives the pulse with no strobe activity.
- R9: During reset the strobe, busy, completion and error outputs are low.
- R10: Both error flags stay set until the next start request, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| dir_i | input | 1 | Requested shift direction |
| sel_i | input | 4 | Requested counter-select code |
| steps_i | input | STEP_W | Number of shifts to perform |
| pll_done_i | input | 1 | Asynchronous acknowledge from the PLL |
| ps_dir_o | output | 1 | Direction to the PLL |
| ps_sel_o | output | 4 | Counter select to the PLL |
| ps_step_o | output | 1 | Phase-step strobe to the PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_timeout_o | output | 1 | Sticky acknowledge-timeout flag |
| err_sel_o | output | 1 | Sticky rejected-select flag |

## Verification
The assertions assume that the PLL drops its done flag once a strobe starts. They also assume the flag does not rise again until the strobe has fallen, so that every acknowledge shows up as a clean rising edge during the wait. The bench's PLL stand-in drives done only on falling clock edges. It lowers done on a strobe rise and raises it a chosen number of cycles after the strobe falls, or never, to force a timeout. One case keeps done high throughout to show that a level alone completes nothing. Start, direction, select and count are likewise changed only on falling edges and held stable across the rising edge that samples them.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/done_sync.sv
module done_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], async_i};
        end
    end

    // edge taken between the last synchroniser flop and one extra history flop
    assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sel_check.sv
module sel_check #(
    parameter bit WIDE_SEL = 1'b0
) (
    input  logic [phase_step_pkg::SEL_W-1:0] sel_i,
    output logic                             ok_o
);
    localparam logic [phase_step_pkg::SEL_W-1:0] LAST_CODE  = 4'd11;
    localparam logic [phase_step_pkg::SEL_W-1:0] WIDE_FIRST = 4'd8;
    localparam logic [phase_step_pkg::SEL_W-1:0] WIDE_LAST  = 4'd10;

    generate
        if (WIDE_SEL) begin : g_wide
            assign ok_o = (sel_i <= LAST_CODE);
        end else begin : g_narrow
            assign ok_o = (sel_i <= LAST_CODE) &&
                          !((sel_i >= WIDE_FIRST) && (sel_i <= WIDE_LAST));
        end
    endgenerate
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != {W{1'b1}}) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq
    import phase_step_pkg::*;
#(
    parameter int STEP_W      = 8,
    parameter int HOLD_CYC    = 2,
    parameter int TIMEOUT_CYC = 1024,
    parameter bit WIDE_SEL    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [3:0]        sel_i,
    input  logic [STEP_W-1:0] steps_i,
    input  logic              pll_done_i,
    output logic              ps_dir_o,
    output logic [3:0]        ps_sel_o,
    output logic              ps_step_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_timeout_o,
    output logic              err_sel_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + HOLD_CYC + 1);
    localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] TMO_LAST  = TMR_W'(TIMEOUT_CYC - 1);
    localparam logic [STEP_W-1:0] ONE_STEP = STEP_W'(1);

    seq_state_t state, nxt;

    logic              done_rise;
    logic              sel_ok;
    logic [TMR_W-1:0]  tmr;
    logic              tmr_clr;
    logic [STEP_W-1:0] remain;
    logic              dir_q;
    logic [3:0]        sel_q;
    logic              err_to_q;
    logic              err_sel_q;
    logic              accept;
    logic              hold_end;
    logic              tmo_hit;

    done_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pll_done_i),
        .rise_o  (done_rise)
    );

    sel_check #(.WIDE_SEL(WIDE_SEL)) u_sel (
        .sel_i (sel_i),
        .ok_o  (sel_ok)
    );

    step_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr)
    );

    assign accept   = (state == ST_IDLE) && start_i;
    assign hold_end = (tmr == HOLD_LAST);
    assign tmo_hit  = (tmr == TMO_LAST);
    assign tmr_clr  = (state != nxt);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_i && sel_ok) begin
                    nxt = (steps_i == '0) ? ST_FINISH : ST_SETUP;
                end
            end
            ST_SETUP:  nxt = ST_STROBE;
            ST_STROBE: begin
                if (hold_end) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (done_rise) begin
                    nxt = (remain == ONE_STEP) ? ST_FINISH : ST_SETUP;
                end else if (tmo_hit) begin
                    nxt = ST_IDLE;
                end
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // request capture, step countdown and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            dir_q     <= 1'b0;
            sel_q     <= '0;
            err_to_q  <= 1'b0;
            err_sel_q <= 1'b0;
        end else begin
            if (accept) begin
                err_to_q  <= 1'b0;
                err_sel_q <= !sel_ok;
                if (sel_ok) begin
                    dir_q  <= dir_i;
                    sel_q  <= sel_i;
                    remain <= steps_i;
                end
            end
            if (state == ST_WAIT) begin
                if (done_rise) begin
                    remain <= remain - 1'b1;
                end else if (tmo_hit) begin
                    err_to_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        ps_step_o = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state)
            ST_IDLE:   busy_o    = 1'b0;
            ST_SETUP:  ps_step_o = 1'b0;
            ST_STROBE: ps_step_o = 1'b1;
            ST_WAIT:   ps_step_o = 1'b0;
            ST_FINISH: done_o    = 1'b1;
            default:   busy_o    = 1'b0;
        endcase
    end

    assign ps_dir_o      = dir_q;
    assign ps_sel_o      = sel_q;
    assign err_timeout_o = err_to_q;
    assign err_sel_o     = err_sel_q;
endmodule

// File: rtl/phase_step_chk.sv
module phase_step_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ps_dir_o,
    input logic [3:0] ps_sel_o,
    input logic       ps_step_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_timeout_o,
    input logic       err_sel_o
);
    assert_strobe_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps_step_o) |-> $past(ps_step_o, 2));

    assert_sel_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ps_step_o |-> ($stable(ps_sel_o) && $stable(ps_dir_o)));

    assert_setup_before_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps_step_o) |-> $past(busy_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ps_step_o);

    assert_timeout_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout_o) |-> (!busy_o && !done_o));

    assert_sel_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sel_o) |-> (!busy_o && !ps_step_o));
endmodule

bind phase_step_seq phase_step_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ps_dir_o      (ps_dir_o),
    .ps_sel_o      (ps_sel_o),
    .ps_step_o     (ps_step_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_timeout_o (err_timeout_o),
    .err_sel_o     (err_sel_o)
);

// File: tb/phase_step_seq_tb.sv
module phase_step_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP_W = 8;
    localparam int HOLD   = 3;
    localparam int TMO    = 20;
    localparam int LIMIT  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic dir_i = 1'b0;
    logic [3:0] sel_i = '0;
    logic [STEP_W-1:0] steps_i = '0;
    logic pll_done_i = 1'b1;
    logic ps_dir_o, ps_step_o, busy_o, done_o, err_timeout_o, err_sel_o;
    logic [3:0] ps_sel_o;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_step_seq #(.STEP_W(STEP_W), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO), .WIDE_SEL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i), .sel_i(sel_i),
        .steps_i(steps_i), .pll_done_i(pll_done_i), .ps_dir_o(ps_dir_o), .ps_sel_o(ps_sel_o),
        .ps_step_o(ps_step_o), .busy_o(busy_o), .done_o(done_o),
        .err_timeout_o(err_timeout_o), .err_sel_o(err_sel_o));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // PLL stand-in: drops done on strobe rise, raises it pll_lat cycles after strobe fall
    int  pll_lat = 2;
    bit  pll_drop = 1'b1;
    int  lat_cnt = -1;
    bit  prev_step = 1'b0;
    int  pulses = 0;
    always @(negedge clk) begin
        if (ps_step_o && !prev_step) begin
            pulses++;
            if (pll_drop) pll_done_i <= 1'b0;
        end
        if (!ps_step_o && prev_step) lat_cnt = pll_lat;
        else if (lat_cnt > 0) lat_cnt--;
        if (lat_cnt == 0) begin
            pll_done_i <= 1'b1;
            lat_cnt = -1;
        end
        prev_step = ps_step_o;
    end

    // behavioural reference: 0 idle, 1 setup, 2 strobe, 3 wait, 4 finish
    int mst = 0, mtim = 0, mrem = 0;
    bit mdir = 0, merr_to = 0, merr_sel = 0;
    int msel = 0;
    bit q1 = 0, q2 = 0, q3 = 0;

    function automatic bit code_ok(input int s);
        return (s <= 11) && !(s >= 8 && s <= 10);
    endfunction

    always @(posedge clk) begin
        bit rise;
        if (!rst_n) begin
            mst = 0; mtim = 0; mrem = 0; mdir = 0; msel = 0;
            merr_to = 0; merr_sel = 0; q1 = 0; q2 = 0; q3 = 0;
        end else begin
            rise = q2 && !q3;
            q3 = q2; q2 = q1; q1 = pll_done_i;
            case (mst)
                0: if (start_i) begin
                       merr_to = 0;
                       merr_sel = !code_ok(int'(sel_i));
                       if (!merr_sel) begin
                           mdir = dir_i; msel = int'(sel_i); mrem = int'(steps_i);
                           mst = (mrem == 0) ? 4 : 1;
                           mtim = 0;
                       end
                   end
                1: begin mst = 2; mtim = 0; end
                2: if (mtim == HOLD-1) begin mst = 3; mtim = 0; end else mtim++;
                3: if (rise) begin
                       if (mrem == 1) mst = 4;
                       else begin mrem--; mst = 1; end
                   end else if (mtim == TMO-1) begin
                       merr_to = 1; mst = 0;
                   end else mtim++;
                default: mst = 0;
            endcase
        end
    end

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 ps_step_o", int'(ps_step_o), int'(mst == 2));
            check("R7 busy_o", int'(busy_o), int'(mst != 0));
            check("R8 done_o", int'(done_o), int'(mst == 4));
            check("R6 err_timeout_o", int'(err_timeout_o), int'(merr_to));
            check("R5 err_sel_o", int'(err_sel_o), int'(merr_sel));
            if (mst != 0) begin
                check("R1 ps_dir_o", int'(ps_dir_o), int'(mdir));
                check("R1 ps_sel_o", int'(ps_sel_o), msel);
            end
        end
    end

    task automatic run(input bit d, input int s, input int n, input int exp_pulses, input string tag);
        int base;
        @(negedge clk);
        base = pulses;
        start_i = 1'b1; dir_i = d; sel_i = 4'(s); steps_i = STEP_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 2000 && mst != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check({tag, " strobe count"}, pulses - base, exp_pulses);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check("R9 reset ps_step_o", int'(ps_step_o), 0);
                check("R9 reset busy_o", int'(busy_o), 0);
                check("R9 reset done_o", int'(done_o), 0);
                check("R9 reset errors", int'(err_timeout_o | err_sel_o), 0);
                rst_n = 1'b1;
                repeat (4) @(negedge clk);

                run(1'b1, 1, 3, 3, "R3 C0 three steps");
                pll_lat = 5;
                run(1'b0, 11, 1, 1, "R3 feedback one step");
                run(1'b1, 0, 0, 0, "R8 zero steps");
                run(1'b0, 8, 2, 0, "R5 C7 rejected");
                run(1'b1, 13, 2, 0, "R5 code 13 rejected");
                pll_lat = 1;
                run(1'b1, 7, 2, 2, "R10 C6 clears error");
                check("R10 err_sel cleared", int'(err_sel_o), 0);
                pll_lat = 100000;
                run(1'b0, 3, 2, 1, "R6 timeout");
                check("R6 flag set", int'(err_timeout_o), 1);
                pll_lat = 0;
                run(1'b0, 2, 1, 1, "R10 fast ack clears timeout");
                check("R10 err_timeout cleared", int'(err_timeout_o), 0);
                pll_drop = 1'b0;
                run(1'b1, 4, 1, 1, "R4 level without edge");
                check("R4 timeout on held level", int'(err_timeout_o), 1);
                pll_drop = 1'b1;
                pll_lat = 3;
                // start again while busy: the second request is ignored
                @(negedge clk);
                start_i = 1'b1; dir_i = 1'b1; sel_i = 4'd5; steps_i = STEP_W'(2);
                @(negedge clk);
                start_i = 1'b0;
                repeat (3) @(negedge clk);
                start_i = 1'b1; dir_i = 1'b0; sel_i = 4'd9; steps_i = STEP_W'(6);
                @(negedge clk);
                start_i = 1'b0;
                for (int i = 0; i < 2000 && mst != 0; i++) @(negedge clk);
                repeat (2) @(negedge clk);
                check("R7 start while busy ignored, err_sel", int'(err_sel_o), 0);
                check("R7 final sel kept", int'(ps_sel_o), 5);
            end
            begin
                repeat (LIMIT) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule